// File: doc/BRIEF.md
# Super I/O Configuration Decoder

This block is the configuration front end of an integrated Super I/O. Software reaches a 32-entry byte register file through two adjacent I/O ports. A byte written to the lower port picks a register, and the upper port then reads or writes that register. A host bridge drives a separate sideband write bus. That bus carries a control byte with two gate bits, plus the interrupt and DMA channel choices for the floppy controller, the parallel port and both serial ports.

The block decodes the register file into the information each function engine needs. For the floppy controller, the parallel port and the two serial ports it produces a base I/O address and an enable. The parallel port also gets a window-width flag. All decoded values are held in registers, and they change on the same clock edge that stores the controlling write. Reset is asynchronous and active low.

Top module: `sio_cfg_decoder`

## Requirements
- R1: After reset, register 0x00 reads 0x3C, register 0x02 reads 0x03, register 0x03 reads 0xFC, register 0x06 reads 0xDE, register 0x07 reads 0xFE, register 0x08 reads 0xBE, and every other register reads 0x00. The selected index is 0, the floppy DMA channel is 2, the parallel DMA channel is 3, all IRQ selections are 0 and the control byte is 0.
- R2: The pair (index port at IDX_PORT = 0x3F0, data port at 0x3F1) responds only while control bit 0 is 1. While it responds, io_hit is 1 for either address. Otherwise io_hit is 0, reads return 0xFF and writes are dropped.
- R3: Writes through the pair change nothing unless control bit 1 is also 1.
- R4: A write to the index port keeps bits 4:0 of the data as the selected index. A read of the index port returns that index with bits 7:5 forced to 1.
- R5: A read of the data port returns the selected register. A write to the data port stores the byte in the selected register.
- R6: Registers 0x00, 0x01, 0x04 and 0x05 cannot be written. Writes to them leave their contents unchanged.
- R7: The floppy base is register 0x03 with bits 1:0 cleared, shifted left by 2. It is enabled by bit 4 of register 0x02.
- R8: Serial port 1 base is register 0x07 with bit 0 cleared, shifted left by 2, and is enabled by bit 2 of register 0x02. Serial port 2 uses register 0x08 in the same way and is enabled by bit 3 of register 0x02.
- R9: The parallel mode is bits 1:0 of register 0x02. Mode 2 selects an 8-byte window: lpt_wide is 1 and bit 2 of the base is cleared. Any other mode selects a 4-byte window. Mode 3 disables the port. The raw base is register 0x06 shifted left by 2.
- R10: The parallel port is enabled only when its base is at least 0x100 and at most 0x3F8 (8-byte window) or 0x3FC (4-byte window).
- R11: Sideband offset 0x50 sets the floppy DMA channel (bits 1:0) and the parallel DMA channel (bits 3:2). Offset 0x51 sets the floppy IRQ (bits 3:0) and the parallel IRQ (bits 7:4). Offset 0x52 sets the serial 1 IRQ (bits 3:0) and the serial 2 IRQ (bits 7:4). Offset 0x85 is the control byte. Other offsets have no effect.
- R12: Decoded bases and enables keep their old value until the clock edge that stores a data-port write. They show the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O cycle address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0xFF when not claimed) |
| io_hit | output | 1 | Address claimed by the port pair |
| sb_we | input | 1 | Sideband write strobe |
| sb_addr | input | 8 | Sideband register offset |
| sb_wdata | input | 8 | Sideband write data |
| fdc_base | output | 10 | Floppy controller base address |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_irq | output | 4 | Floppy IRQ number |
| fdc_dma | output | 2 | Floppy DMA channel |
| lpt_base | output | 10 | Parallel port base address |
| lpt_en | output | 1 | Parallel port enable |
| lpt_wide | output | 1 | Parallel port uses the 8-byte window |
| lpt_irq | output | 4 | Parallel IRQ number |
| lpt_dma | output | 2 | Parallel DMA channel |
| uart_base | output | 20 | Serial bases, port 2 in bits 19:10 and port 1 in bits 9:0 |
| uart_en | output | 2 | Serial enables, bit 0 for port 1 |
| uart_irq | output | 8 | Serial IRQs, port 2 in bits 7:4 |

## Verification
The bench probes the parallel range limits exactly at 0x0FC, 0x100, 0x3F8 and 0x3FC in both window widths. A design that used the wrong limit or forgot to clear bit 2 in the wide window would enable a port that should be off, or report an unaligned base. It also writes to each read-only register and checks that the value does not change. It writes index bytes with the upper bits set, so a design that kept all eight bits, or skipped the 0xE0 padding on readback, shows a wrong index. Finally, it checks that writes are dropped when only the decode bit is set, and that outputs do not move before the write edge. A design that merged the two gate bits, or decoded outputs a cycle late or early, is caught by those checks.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int DW     = 8;
  localparam int IW     = 5;
  localparam int NREG   = 1 << IW;
  localparam int BASE_W = DW + 2;
  localparam int NUART  = 2;
  localparam int IRQ_W  = 4;
  localparam int DMA_W  = 2;

  localparam int REG_FUNC  = 2;
  localparam int REG_FDC   = 3;
  localparam int REG_LPT   = 6;
  localparam int REG_UART0 = 7;

  localparam logic [BASE_W-1:0] LPT_BASE_MIN   = 10'h100;
  localparam logic [BASE_W-1:0] LPT_LIM_NARROW = 10'h3FC;
  localparam logic [BASE_W-1:0] LPT_LIM_WIDE   = 10'h3F8;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [1:0] {
    LPT_MODE_A    = 2'd0,
    LPT_MODE_B    = 2'd1,
    LPT_MODE_WIDE = 2'd2,
    LPT_MODE_OFF  = 2'd3
  } lpt_mode_e;

  typedef struct packed {
    logic [BASE_W-1:0]            fdc_base;
    logic                         fdc_en;
    logic [BASE_W-1:0]            lpt_base;
    logic                         lpt_en;
    logic                         lpt_wide;
    logic [NUART-1:0][BASE_W-1:0] uart_base;
    logic [NUART-1:0]             uart_en;
  } io_map_t;

  function automatic byte_t reg_init(input int unsigned i);
    byte_t v;
    case (i)
      0:       v = 8'h3C;
      2:       v = 8'h03;
      3:       v = 8'hFC;
      6:       v = 8'hDE;
      7:       v = 8'hFE;
      8:       v = 8'hBE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic reg_is_ro(input logic [IW-1:0] i);
    return (i == 5'd0) || (i == 5'd1) || (i == 5'd4) || (i == 5'd5);
  endfunction
endpackage

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_we,
  input  logic                      dat_we,
  input  byte_t                     wdata,
  input  logic                      sel_index,
  output byte_t                     rdata,
  output logic [NREG-1:0][DW-1:0]   regs_q,
  output logic [NREG-1:0][DW-1:0]   regs_d,
  output logic                      reg_we
);
  localparam byte_t IDX_PAD = ~byte_t'((1 << IW) - 1);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  logic          idx_en;

  always_comb begin
    idx_en = idx_we;
    idx_d  = wdata[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    reg_we = dat_we && !reg_is_ro(idx_q);
    regs_d = regs_q;
    if (reg_we) begin
      regs_d[idx_q] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        regs_q[i] <= reg_init(i);
      end
    end else if (reg_we) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    if (sel_index) begin
      rdata = byte_t'(idx_q) | IDX_PAD;
    end else begin
      rdata = regs_q[idx_q];
    end
  end

  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && reg_is_ro(idx_q)) |=> $stable(regs_q)); // R6

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (idx_q == $past(wdata[IW-1:0]))); // R4

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(regs_q)); // R3
endmodule

// File: rtl/sio_cfg_sideband.sv
module sio_cfg_sideband
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] OFS_DMA   = 8'h50,
  parameter logic [7:0] OFS_IRQ_A = 8'h51,
  parameter logic [7:0] OFS_IRQ_B = 8'h52,
  parameter logic [7:0] OFS_CTRL  = 8'h85,
  parameter logic [DMA_W-1:0] FDC_DMA_INIT = 2'd2,
  parameter logic [DMA_W-1:0] LPT_DMA_INIT = 2'd3
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sb_we,
  input  logic [7:0]                   sb_addr,
  input  byte_t                        sb_wdata,
  output logic                         port_on,
  output logic                         cfg_wen,
  output logic [IRQ_W-1:0]             fdc_irq,
  output logic [IRQ_W-1:0]             lpt_irq,
  output logic [NUART-1:0][IRQ_W-1:0]  uart_irq,
  output logic [DMA_W-1:0]             fdc_dma,
  output logic [DMA_W-1:0]             lpt_dma
);
  localparam byte_t DMA_INIT = byte_t'({LPT_DMA_INIT, FDC_DMA_INIT});

  byte_t      dma_q, irqa_q, irqb_q;
  logic [1:0] ctrl_q;
  logic       dma_en, irqa_en, irqb_en, ctrl_en;

  always_comb begin
    dma_en  = sb_we && (sb_addr == OFS_DMA);
    irqa_en = sb_we && (sb_addr == OFS_IRQ_A);
    irqb_en = sb_we && (sb_addr == OFS_IRQ_B);
    ctrl_en = sb_we && (sb_addr == OFS_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q  <= DMA_INIT;
      irqa_q <= '0;
      irqb_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (dma_en)  dma_q  <= sb_wdata;
      if (irqa_en) irqa_q <= sb_wdata;
      if (irqb_en) irqb_q <= sb_wdata;
      if (ctrl_en) ctrl_q <= sb_wdata[1:0];
    end
  end

  always_comb begin
    port_on = ctrl_q[0];
    cfg_wen = ctrl_q[1];
    fdc_dma = dma_q[DMA_W-1:0];
    lpt_dma = dma_q[2*DMA_W-1:DMA_W];
    fdc_irq = irqa_q[IRQ_W-1:0];
    lpt_irq = irqa_q[2*IRQ_W-1:IRQ_W];
  end

  for (genvar g = 0; g < NUART; g++) begin : g_uirq
    assign uart_irq[g] = irqb_q[g*IRQ_W +: IRQ_W];
  end

  AST_SB_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_we && sb_addr == OFS_IRQ_A) |=> (fdc_irq == $past(sb_wdata[IRQ_W-1:0]))); // R11

  AST_SB_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_we && sb_addr == OFS_DMA) |=> (lpt_dma == $past(sb_wdata[3:2]))); // R11
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
(
  input  byte_t                    func_cfg,
  input  byte_t                    fdc_cfg,
  input  byte_t                    lpt_cfg,
  input  logic [NUART-1:0][DW-1:0] uart_cfg,
  output io_map_t                  map
);
  lpt_mode_e                    mode;
  logic [BASE_W-1:0]            lpt_raw, lpt_b, lpt_lim;
  logic                         wide;
  logic [NUART-1:0][BASE_W-1:0] ub;
  logic [NUART-1:0]             ue;

  for (genvar g = 0; g < NUART; g++) begin : g_uart
    assign ub[g] = {uart_cfg[g][DW-1:1], 3'b000};
    assign ue[g] = func_cfg[2 + g];
  end

  always_comb begin
    mode    = lpt_mode_e'(func_cfg[1:0]);
    wide    = (mode == LPT_MODE_WIDE);
    lpt_raw = {lpt_cfg, 2'b00};
    lpt_b   = wide ? {lpt_raw[BASE_W-1:3], 3'b000} : lpt_raw;
    lpt_lim = wide ? LPT_LIM_WIDE : LPT_LIM_NARROW;

    map.fdc_base  = {fdc_cfg[DW-1:2], 4'b0000};
    map.fdc_en    = func_cfg[4];
    map.lpt_base  = lpt_b;
    map.lpt_wide  = wide;
    map.lpt_en    = (mode != LPT_MODE_OFF) && (lpt_b >= LPT_BASE_MIN) && (lpt_b <= lpt_lim);
    map.uart_base = ub;
    map.uart_en   = ue;
  end
endmodule

// File: rtl/sio_cfg_decoder.sv
module sio_cfg_decoder
  import sio_cfg_pkg::*;
#(
  parameter int            ADDR_W    = 16,
  parameter logic [15:0]   IDX_PORT  = 16'h03F0,
  parameter logic [15:0]   DATA_PORT = 16'h03F1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic                      io_rd,
  input  logic                      io_wr,
  input  logic [DW-1:0]             io_wdata,
  output logic [DW-1:0]             io_rdata,
  output logic                      io_hit,
  input  logic                      sb_we,
  input  logic [7:0]                sb_addr,
  input  logic [DW-1:0]             sb_wdata,
  output logic [BASE_W-1:0]         fdc_base,
  output logic                      fdc_en,
  output logic [IRQ_W-1:0]          fdc_irq,
  output logic [DMA_W-1:0]          fdc_dma,
  output logic [BASE_W-1:0]         lpt_base,
  output logic                      lpt_en,
  output logic                      lpt_wide,
  output logic [IRQ_W-1:0]          lpt_irq,
  output logic [DMA_W-1:0]          lpt_dma,
  output logic [NUART*BASE_W-1:0]   uart_base,
  output logic [NUART-1:0]          uart_en,
  output logic [NUART*IRQ_W-1:0]    uart_irq
);
  logic port_on, cfg_wen;
  logic at_idx, at_dat, idx_we, dat_we, reg_we;
  byte_t rf_rdata;
  logic [NREG-1:0][DW-1:0] regs_q, regs_d;
  logic [NUART-1:0][IRQ_W-1:0] uirq;
  logic [NUART-1:0][DW-1:0] ucfg_d, ucfg_rst;
  io_map_t map_d, map_rst, map_q;

  always_comb begin
    at_idx   = (io_addr == ADDR_W'(IDX_PORT));
    at_dat   = (io_addr == ADDR_W'(DATA_PORT));
    io_hit   = port_on && (at_idx || at_dat);
    idx_we   = io_wr && port_on && cfg_wen && at_idx;
    dat_we   = io_wr && port_on && cfg_wen && at_dat;
    io_rdata = (io_rd && io_hit) ? rf_rdata : 8'hFF;
  end

  sio_cfg_sideband u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sb_we    (sb_we),
    .sb_addr  (sb_addr),
    .sb_wdata (sb_wdata),
    .port_on  (port_on),
    .cfg_wen  (cfg_wen),
    .fdc_irq  (fdc_irq),
    .lpt_irq  (lpt_irq),
    .uart_irq (uirq),
    .fdc_dma  (fdc_dma),
    .lpt_dma  (lpt_dma)
  );

  sio_cfg_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (idx_we),
    .dat_we    (dat_we),
    .wdata     (io_wdata),
    .sel_index (at_idx),
    .rdata     (rf_rdata),
    .regs_q    (regs_q),
    .regs_d    (regs_d),
    .reg_we    (reg_we)
  );

  for (genvar g = 0; g < NUART; g++) begin : g_ucfg
    assign ucfg_d[g]   = regs_d[REG_UART0 + g];
    assign ucfg_rst[g] = reg_init(REG_UART0 + g);
  end

  sio_cfg_decode u_dec (
    .func_cfg (regs_d[REG_FUNC]),
    .fdc_cfg  (regs_d[REG_FDC]),
    .lpt_cfg  (regs_d[REG_LPT]),
    .uart_cfg (ucfg_d),
    .map      (map_d)
  );

  sio_cfg_decode u_dec_rst (
    .func_cfg (reg_init(REG_FUNC)),
    .fdc_cfg  (reg_init(REG_FDC)),
    .lpt_cfg  (reg_init(REG_LPT)),
    .uart_cfg (ucfg_rst),
    .map      (map_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= map_rst;
    end else if (reg_we) begin
      map_q <= map_d;
    end
  end

  always_comb begin
    fdc_base  = map_q.fdc_base;
    fdc_en    = map_q.fdc_en;
    lpt_base  = map_q.lpt_base;
    lpt_en    = map_q.lpt_en;
    lpt_wide  = map_q.lpt_wide;
    uart_base = map_q.uart_base;
    uart_en   = map_q.uart_en;
    uart_irq  = uirq;
  end

  AST_LPT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_en |-> (lpt_base >= LPT_BASE_MIN)); // R10

  AST_LPT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lpt_en |-> (regs_q[REG_FUNC][1:0] != 2'b11)); // R9

  AST_UART_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en[0] |-> regs_q[REG_FUNC][2]); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_we |=> $stable(map_q)); // R12
endmodule

// File: tb/sio_cfg_decoder_test.sv
module sio_cfg_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_hit;
  logic        sb_we;
  logic [7:0]  sb_addr, sb_wdata;
  logic [9:0]  fdc_base, lpt_base;
  logic        fdc_en, lpt_en, lpt_wide;
  logic [3:0]  fdc_irq, lpt_irq;
  logic [1:0]  fdc_dma, lpt_dma, uart_en;
  logic [19:0] uart_base;
  logic [7:0]  uart_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  sio_cfg_decoder uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit), .sb_we(sb_we),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .fdc_base(fdc_base), .fdc_en(fdc_en),
    .fdc_irq(fdc_irq), .fdc_dma(fdc_dma), .lpt_base(lpt_base), .lpt_en(lpt_en),
    .lpt_wide(lpt_wide), .lpt_irq(lpt_irq), .lpt_dma(lpt_dma), .uart_base(uart_base),
    .uart_en(uart_en), .uart_irq(uart_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic h);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata; h = io_hit;
    io_rd = 1'b0;
  endtask

  task automatic sb_write(input logic [7:0] a, input logic [7:0] d);
    sb_addr = a; sb_wdata = d; sb_we = 1'b1;
    @(negedge clk);
    sb_we = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    io_write(16'h3F0, idx);
    io_write(16'h3F1, d);
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
    logic h;
    io_write(16'h3F0, idx);
    io_read(16'h3F1, d, h);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic h;
    io_read(16'h3F0, d, h);
    chk("R2 io_hit before enable", h, 0);
    chk("R2 rdata before enable", d, 8'hFF);
    chk("R1 fdc_base", fdc_base, 10'h3F0);
    chk("R1 fdc_en", fdc_en, 0);
    chk("R1 uart1 base", uart_base[9:0], 10'h3F8);
    chk("R1 uart2 base", uart_base[19:10], 10'h2F8);
    chk("R1 uart_en", uart_en, 0);
    chk("R1 lpt_en (mode 3)", lpt_en, 0);
    chk("R1 lpt_base", lpt_base, 10'h378);
    chk("R1 fdc_dma", fdc_dma, 2);
    chk("R1 lpt_dma", lpt_dma, 3);
    chk("R1 irqs", {fdc_irq, lpt_irq, uart_irq}, 0);
  endtask

  task automatic t_gate;
    logic [7:0] d; logic h;
    sb_write(8'h85, 8'h02);
    io_write(16'h3F0, 8'h03);
    io_write(16'h3F1, 8'h11);
    io_read(16'h3F1, d, h);
    chk("R2 no hit with bit0 clear", h, 0);
    sb_write(8'h85, 8'h01);
    io_read(16'h3F0, d, h);
    chk("R2 hit index port", h, 1);
    chk("R2 index unchanged when bit0 clear", d, 8'hE0);
    io_write(16'h3F0, 8'h03);
    io_read(16'h3F0, d, h);
    chk("R3 index write ignored", d, 8'hE0);
    io_read(16'h3F1, d, h);
    chk("R5 data reads reg0", d, 8'h3C);
    chk("R1 reg0 reset", d, 8'h3C);
    sb_write(8'h85, 8'h03);
    read_reg(8'h03, d);
    chk("R3 reg3 unchanged", d, 8'hFC);
    read_reg(8'h08, d);
    chk("R1 reg8 reset", d, 8'hBE);
    read_reg(8'h09, d);
    chk("R1 reg9 reset", d, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] d; logic h;
    io_write(16'h3F0, 8'hF3);
    io_read(16'h3F0, d, h);
    chk("R4 index readback", d, 8'hF3);
    io_write(16'h3F1, 8'h5A);
    io_read(16'h3F1, d, h);
    chk("R5 data readback", d, 8'h5A);
    io_write(16'h3F0, 8'h33);
    io_read(16'h3F1, d, h);
    chk("R4 upper index bits dropped", d, 8'h5A);
  endtask

  task automatic t_ro;
    logic [7:0] d;
    logic [7:0] ro_idx [4] = '{8'h00, 8'h01, 8'h04, 8'h05};
    logic [7:0] ro_exp [4] = '{8'h3C, 8'h00, 8'h00, 8'h00};
    for (int i = 0; i < 4; i++) begin
      set_reg(ro_idx[i], 8'hA5);
      read_reg(ro_idx[i], d);
      chk($sformatf("R6 ro reg %0h", ro_idx[i]), d, ro_exp[i]);
    end
  endtask

  task automatic t_fdc;
    set_reg(8'h03, 8'hC7);
    chk("R7 fdc_base", fdc_base, 10'h310);
    chk("R7 fdc_en still off", fdc_en, 0);
    set_reg(8'h02, 8'h10);
    chk("R7 fdc_en", fdc_en, 1);
    chk("R8 uarts off", uart_en, 0);
    chk("R9 lpt mode0 narrow", lpt_wide, 0);
    chk("R9 lpt mode0 enabled", lpt_en, 1);
  endtask

  task automatic t_uart;
    set_reg(8'h07, 8'h7F);
    set_reg(8'h08, 8'h23);
    set_reg(8'h02, 8'h0C);
    chk("R8 uart1 base", uart_base[9:0], 10'h1F8);
    chk("R8 uart2 base", uart_base[19:10], 10'h088);
    chk("R8 uart_en both", uart_en, 2'b11);
    chk("R7 fdc off", fdc_en, 0);
    set_reg(8'h02, 8'h04);
    chk("R8 only uart1", uart_en, 2'b01);
  endtask

  task automatic t_lpt;
    set_reg(8'h02, 8'h02);
    set_reg(8'h06, 8'hDF);
    chk("R9 wide flag", lpt_wide, 1);
    chk("R9 wide base bit2 cleared", lpt_base, 10'h378);
    chk("R9 wide enabled", lpt_en, 1);
    set_reg(8'h06, 8'hFF);
    chk("R10 wide base 3F8", lpt_base, 10'h3F8);
    chk("R10 wide at limit enabled", lpt_en, 1);
    set_reg(8'h02, 8'h01);
    chk("R10 narrow base 3FC", lpt_base, 10'h3FC);
    chk("R10 narrow at limit enabled", lpt_en, 1);
    set_reg(8'h06, 8'h3F);
    chk("R10 below 0x100 off", lpt_en, 0);
    set_reg(8'h06, 8'h40);
    chk("R10 at 0x100 on", lpt_en, 1);
    set_reg(8'h02, 8'h03);
    chk("R9 mode3 off", lpt_en, 0);
  endtask

  task automatic t_timing;
    io_write(16'h3F0, 8'h03);
    io_addr = 16'h3F1; io_wdata = 8'h30; io_wr = 1'b1;
    #1;
    chk("R12 old value before edge", fdc_base, 10'h310);
    @(negedge clk);
    io_wr = 1'b0;
    chk("R12 new value after edge", fdc_base, 10'h0C0);
  endtask

  task automatic t_sideband;
    sb_write(8'h50, 8'h0B);
    chk("R11 fdc_dma", fdc_dma, 3);
    chk("R11 lpt_dma", lpt_dma, 2);
    sb_write(8'h51, 8'h7E);
    chk("R11 fdc_irq", fdc_irq, 4'hE);
    chk("R11 lpt_irq", lpt_irq, 4'h7);
    sb_write(8'h52, 8'h43);
    chk("R11 uart irqs", uart_irq, 8'h43);
    sb_write(8'h53, 8'hFF);
    chk("R11 other offset no effect", {fdc_irq, lpt_irq, uart_irq, fdc_dma, lpt_dma}, {4'hE, 4'h7, 8'h43, 2'd3, 2'd2});
  endtask

  initial begin
    rst_n = 1'b0; io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
    sb_we = 0; sb_addr = '0; sb_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gate;
    t_index;
    t_ro;
    t_fdc;
    t_uart;
    t_lpt;
    t_timing;
    t_sideband;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule